// File: doc/BRIEF.md
# Posted Write Buffer with Stall Control

This block sits between a write-through cache and a slow main-memory port. Each CPU write is captured as an address/data entry in a parameterised queue of registers. The processor moves on at once, and the block sends the queued entries to memory in the background, one transaction at a time and oldest first.

The block decides when the CPU must stall. A write stalls only when there is no free entry. A read that hits the cache is never held up. A read miss waits until every posted write has reached memory, and only then is it told that its line fetch may go out.

An external bus master asks for memory with a request line. It is granted only once memory holds every posted write and no transaction is in flight. New CPU writes are held off for as long as the grant lasts.

Top module: `wpb_top`

## Requirements
- R1: After reset, count_o is 0, empty_o is 1, full_o is 0, mem_req_o is 0 and ext_gnt_o is 0. With no CPU request, cpu_stall_o is 0.
- R2: A write (cpu_req_i=1, cpu_we_i=1) that arrives while at least one entry is free is accepted without stalling, and count_o rises by one after the next clock edge.
- R3: Entries go to memory in the order they were written. mem_req_o rises one cycle after the queue becomes non-empty while idle. mem_addr_o and mem_wdata_o hold the oldest entry and stay stable until mem_ack_i. The entry is removed at the edge where mem_ack_i is seen with mem_req_o high. The next entry is requested in the following cycle, with no gap.
- R4: A write that arrives while all DEPTH entries are occupied, and no acknowledge is seen in that cycle, stalls the CPU and is not queued.
- R5: A write that arrives while the queue is full, in the same cycle as a memory acknowledge, is accepted without a stall, and count_o stays at DEPTH.
- R6: A read that hits the cache (cpu_we_i=0, cache_hit_i=1) never stalls. This holds during draining, with the queue full, and while the external grant is held.
- R7: A read miss (cpu_we_i=0, cache_hit_i=0) stalls while any entry is queued or while the external grant is held. fill_go_o is 1 only for a read miss that is not stalled.
- R8: ext_gnt_o rises one cycle after a cycle in which ext_req_i=1, the queue is empty, no transaction is in flight and no write is accepted. It then stays high while ext_req_i stays high, and falls one cycle after ext_req_i drops.
- R9: While ext_gnt_o is high, CPU writes stall and are not queued. Once the grant is released, writes are accepted again.
- R10: count_o gives the number of queued entries, from 0 to DEPTH. full_o is 1 exactly when the count equals DEPTH, and empty_o is 1 exactly when the count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_req_i | input | 1 | CPU access valid |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | AW | CPU address |
| cpu_wdata_i | input | DW | CPU write data |
| cache_hit_i | input | 1 | Cache lookup result for the current read |
| cpu_stall_o | output | 1 | CPU must hold its request |
| fill_go_o | output | 1 | Read-miss line fetch may be issued |
| mem_req_o | output | 1 | Memory write transaction in flight |
| mem_addr_o | output | AW | Address of the oldest entry |
| mem_wdata_o | output | DW | Data of the oldest entry |
| mem_ack_i | input | 1 | Memory has completed the write |
| ext_req_i | input | 1 | External master requests memory |
| ext_gnt_o | output | 1 | External master may use memory |
| count_o | output | $clog2(DEPTH+1) | Number of queued entries |
| full_o | output | 1 | All entries occupied |
| empty_o | output | 1 | No entries queued |

## Verification
The bench builds the block with DEPTH=3 and 16-bit address and data. The queue therefore fills after three writes. The read and write pointers wrap across a depth that is not a power of two during the fill, drain and simultaneous-write scenarios. A depth of three also leaves more than one entry behind the head, so the back-to-back drain path and the full-plus-acknowledge case are both reached with entries still waiting.

// File: rtl/wpb_pkg.sv
package wpb_pkg;
  typedef enum logic [1:0] {
    REQ_NONE    = 2'd0,
    REQ_WRITE   = 2'd1,
    REQ_RD_HIT  = 2'd2,
    REQ_RD_MISS = 2'd3
  } req_kind_e;
endpackage

// File: rtl/wpb_fifo.sv
module wpb_fifo #(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic [AW-1:0] head_addr_o,
  output logic [DW-1:0] head_data_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [PW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] count_q, count_d;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) begin
        addr_q[i] <= '0;
        data_q[i] <= '0;
      end
    end else if (push_i) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (wr_ptr_q == PW'(i)) begin
          addr_q[i] <= addr_i;
          data_q[i] <= data_i;
        end
      end
    end
  end

  always_comb begin
    unique case ({push_i, pop_i})
      2'b10:   count_d = count_q + 1'b1;
      2'b01:   count_d = count_q - 1'b1;
      default: count_d = count_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push_i) wr_ptr_q <= bump(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= bump(rd_ptr_q);
      count_q <= count_d;
    end
  end

  assign head_addr_o = addr_q[rd_ptr_q];
  assign head_data_o = data_q[rd_ptr_q];
  assign count_o     = count_q;
  assign full_o      = (count_q == CW'(DEPTH));
  assign empty_o     = (count_q == '0);

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && full_o |-> pop_i); // R4
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o); // R3
  AST_COUNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CW'(DEPTH)); // R10
endmodule

// File: rtl/wpb_drain.sv
module wpb_drain (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic empty_i,
  input  logic more_i,
  input  logic mem_ack_i,
  output logic mem_req_o,
  output logic pop_o
);
  logic busy_q;

  // stay busy across an ack when another entry waits behind the head
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_q <= 1'b0;
    else if (busy_q) busy_q <= !mem_ack_i || more_i;
    else             busy_q <= !empty_i;
  end

  assign mem_req_o = busy_q;
  assign pop_o     = busy_q && mem_ack_i;

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o); // R3
  AST_REQ_HAS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !empty_i); // R3
endmodule

// File: rtl/wpb_ctrl.sv
module wpb_ctrl
  import wpb_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cpu_req_i,
  input  logic cpu_we_i,
  input  logic cache_hit_i,
  input  logic full_i,
  input  logic empty_i,
  input  logic busy_i,
  input  logic mem_ack_i,
  input  logic ext_req_i,
  output logic cpu_stall_o,
  output logic fill_go_o,
  output logic push_o,
  output logic ext_gnt_o
);
  req_kind_e kind;
  logic      gnt_q, gnt_d;
  logic      drain_now;
  logic      stall, push, fill;

  always_comb begin
    kind = REQ_NONE;
    if (cpu_req_i) begin
      if (cpu_we_i)         kind = REQ_WRITE;
      else if (cache_hit_i) kind = REQ_RD_HIT;
      else                  kind = REQ_RD_MISS;
    end
  end

  assign drain_now = busy_i && mem_ack_i;

  always_comb begin
    stall = 1'b0;
    push  = 1'b0;
    fill  = 1'b0;
    unique case (kind)
      REQ_WRITE: begin
        stall = gnt_q || (full_i && !drain_now);
        push  = !stall;
      end
      REQ_RD_MISS: begin
        stall = !empty_i || gnt_q;
        fill  = !stall;
      end
      default: ;
    endcase
  end

  // grant only from a quiet queue, and never in a cycle that queues a write
  assign gnt_d = ext_req_i && (gnt_q || (empty_i && !busy_i && !push));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gnt_q <= 1'b0;
    else         gnt_q <= gnt_d;
  end

  assign cpu_stall_o = stall;
  assign push_o      = push;
  assign fill_go_o   = fill;
  assign ext_gnt_o   = gnt_q;

  AST_GNT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_gnt_o |-> empty_i && !busy_i); // R8
  AST_GNT_NO_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_gnt_o |-> !push_o); // R9
  AST_GNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_gnt_o && ext_req_i |=> ext_gnt_o); // R8
  AST_MISS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_go_o |-> empty_i && !ext_gnt_o); // R7
endmodule

// File: rtl/wpb_top.sv
module wpb_top #(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cpu_req_i,
  input  logic          cpu_we_i,
  input  logic [AW-1:0] cpu_addr_i,
  input  logic [DW-1:0] cpu_wdata_i,
  input  logic          cache_hit_i,
  output logic          cpu_stall_o,
  output logic          fill_go_o,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_ack_i,
  input  logic          ext_req_i,
  output logic          ext_gnt_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  logic push, pop, more;

  assign more = (count_o > CW'(1));

  wpb_fifo #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .pop_i       (pop),
    .addr_i      (cpu_addr_i),
    .data_i      (cpu_wdata_i),
    .head_addr_o (mem_addr_o),
    .head_data_o (mem_wdata_o),
    .count_o     (count_o),
    .full_o      (full_o),
    .empty_o     (empty_o)
  );

  wpb_drain u_drain (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .empty_i   (empty_o),
    .more_i    (more),
    .mem_ack_i (mem_ack_i),
    .mem_req_o (mem_req_o),
    .pop_o     (pop)
  );

  wpb_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cpu_req_i   (cpu_req_i),
    .cpu_we_i    (cpu_we_i),
    .cache_hit_i (cache_hit_i),
    .full_i      (full_o),
    .empty_i     (empty_o),
    .busy_i      (mem_req_o),
    .mem_ack_i   (mem_ack_i),
    .ext_req_i   (ext_req_i),
    .cpu_stall_o (cpu_stall_o),
    .fill_go_o   (fill_go_o),
    .push_o      (push),
    .ext_gnt_o   (ext_gnt_o)
  );

  AST_ADDR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> $stable(mem_addr_o) && $stable(mem_wdata_o)); // R3
  AST_HIT_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_req_i && !cpu_we_i && cache_hit_i |-> !cpu_stall_o); // R6
endmodule

// File: tb/tb_wpb_top.sv
`timescale 1ns/1ps
module tb_wpb_top;
  localparam int DEPTH = 3;
  localparam int AW    = 16;
  localparam int DW    = 16;
  localparam int CW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cpu_req_i = 1'b0, cpu_we_i = 1'b0, cache_hit_i = 1'b0;
  logic [AW-1:0] cpu_addr_i = '0;
  logic [DW-1:0] cpu_wdata_i = '0;
  logic          mem_ack_i = 1'b0, ext_req_i = 1'b0;
  logic          cpu_stall_o, fill_go_o, mem_req_o, ext_gnt_o, full_o, empty_o;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_wdata_o;
  logic [CW-1:0] count_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  wpb_top #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .cpu_req_i(cpu_req_i), .cpu_we_i(cpu_we_i), .cpu_addr_i(cpu_addr_i),
    .cpu_wdata_i(cpu_wdata_i), .cache_hit_i(cache_hit_i),
    .cpu_stall_o(cpu_stall_o), .fill_go_o(fill_go_o),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_ack_i(mem_ack_i), .ext_req_i(ext_req_i), .ext_gnt_o(ext_gnt_o),
    .count_o(count_o), .full_o(full_o), .empty_o(empty_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input logic req, input logic we, input logic hit,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
    cpu_req_i = req; cpu_we_i = we; cache_hit_i = hit;
    cpu_addr_i = a;  cpu_wdata_i = d;
    #1;
  endtask

  task automatic idle();
    drive(1'b0, 1'b0, 1'b0, '0, '0);
  endtask

  task automatic t_reset();
    check("R1 count", 32'(count_o), 0);
    check("R1 empty", 32'(empty_o), 1);
    check("R1 full", 32'(full_o), 0);
    check("R1 mem_req", 32'(mem_req_o), 0);
    check("R1 gnt", 32'(ext_gnt_o), 0);
    check("R1 stall", 32'(cpu_stall_o), 0);
  endtask

  task automatic t_fill_drain();
    for (int i = 0; i < DEPTH; i++) begin
      drive(1'b1, 1'b1, 1'b0, AW'(16'h100 + i), DW'(16'hA0 + i));
      check("R2 write no stall", 32'(cpu_stall_o), 0);
      step();
      check("R2 count up", 32'(count_o), 32'(i + 1));
    end
    idle();
    check("R3 req raised", 32'(mem_req_o), 1);
    check("R3 head addr", 32'(mem_addr_o), 32'h100);
    check("R10 full", 32'(full_o), 1);
    check("R10 not empty", 32'(empty_o), 0);
    drive(1'b1, 1'b1, 1'b0, AW'(16'h1FF), DW'(16'hFF));
    check("R4 full stall", 32'(cpu_stall_o), 1);
    step();
    check("R4 count held", 32'(count_o), DEPTH);
    drive(1'b1, 1'b0, 1'b1, AW'(16'h500), '0);
    check("R6 hit while full", 32'(cpu_stall_o), 0);
    drive(1'b1, 1'b0, 1'b0, AW'(16'h500), '0);
    check("R7 miss stalls", 32'(cpu_stall_o), 1);
    check("R7 no fill", 32'(fill_go_o), 0);
    idle();
    mem_ack_i = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      #1;
      check("R3 req during drain", 32'(mem_req_o), 1);
      check("R3 order addr", 32'(mem_addr_o), 32'(16'h100 + i));
      check("R3 order data", 32'(mem_wdata_o), 32'(16'hA0 + i));
      step();
    end
    mem_ack_i = 1'b0;
    #1;
    check("R10 empty after drain", 32'(empty_o), 1);
    check("R10 count zero", 32'(count_o), 0);
    check("R3 req drops", 32'(mem_req_o), 0);
    drive(1'b1, 1'b0, 1'b0, AW'(16'h500), '0);
    check("R7 miss free", 32'(cpu_stall_o), 0);
    check("R7 fill go", 32'(fill_go_o), 1);
    idle();
  endtask

  task automatic t_full_simul();
    for (int i = 0; i < DEPTH; i++) begin
      drive(1'b1, 1'b1, 1'b0, AW'(16'h200 + i), DW'(16'hB0 + i));
      step();
    end
    idle();
    step();
    mem_ack_i = 1'b1;
    drive(1'b1, 1'b1, 1'b0, AW'(16'h2FF), DW'(16'hEE));
    check("R5 full+ack no stall", 32'(cpu_stall_o), 0);
    step();
    mem_ack_i = 1'b0;
    idle();
    check("R5 count stays", 32'(count_o), DEPTH);
    check("R5 still full", 32'(full_o), 1);
    mem_ack_i = 1'b1;
    for (int i = 1; i <= DEPTH; i++) begin
      #1;
      check("R3 order after wrap",
            32'(mem_addr_o), (i < DEPTH) ? 32'(16'h200 + i) : 32'h2FF);
      step();
    end
    mem_ack_i = 1'b0;
    #1;
    check("R10 empty", 32'(empty_o), 1);
  endtask

  task automatic t_grant();
    drive(1'b1, 1'b1, 1'b0, AW'(16'h300), DW'(16'hC0));
    step();
    idle();
    ext_req_i = 1'b1;
    step();
    check("R8 no gnt while pending", 32'(ext_gnt_o), 0);
    mem_ack_i = 1'b1;
    step();
    mem_ack_i = 1'b0;
    #1;
    check("R8 no gnt on drain edge", 32'(ext_gnt_o), 0);
    step();
    check("R8 gnt after empty", 32'(ext_gnt_o), 1);
    drive(1'b1, 1'b1, 1'b0, AW'(16'h301), DW'(16'hC1));
    check("R9 write stalls", 32'(cpu_stall_o), 1);
    step();
    check("R9 write not queued", 32'(count_o), 0);
    drive(1'b1, 1'b0, 1'b1, AW'(16'h600), '0);
    check("R6 hit during gnt", 32'(cpu_stall_o), 0);
    drive(1'b1, 1'b0, 1'b0, AW'(16'h600), '0);
    check("R7 miss during gnt", 32'(cpu_stall_o), 1);
    check("R7 no fill during gnt", 32'(fill_go_o), 0);
    idle();
    step();
    check("R8 gnt held", 32'(ext_gnt_o), 1);
    ext_req_i = 1'b0;
    step();
    check("R8 gnt released", 32'(ext_gnt_o), 0);
    drive(1'b1, 1'b1, 1'b0, AW'(16'h302), DW'(16'hC2));
    check("R9 write after release", 32'(cpu_stall_o), 0);
    step();
    idle();
    check("R9 write queued", 32'(count_o), 1);
    step();
    mem_ack_i = 1'b1;
    #1;
    check("R3 single addr", 32'(mem_addr_o), 32'h302);
    step();
    mem_ack_i = 1'b0;
    #1;
    check("R10 empty end", 32'(empty_o), 1);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    #1;
    t_reset();
    t_fill_drain();
    t_full_simul();
    t_grant();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule